// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Master

This block acts as a microcontroller-style host bus master that performs read cycles on a shared 8-bit address/data bus. A requester presents an address and a width flag on a valid/ready command port. The block then walks a fixed sequence. On a 16-bit read it first drives the upper address byte on its own port. It then puts the low address byte on the shared bus and pulses an address latch enable. Next it lowers chip select, turns the shared bus around to input and pulls the read strobe low. It captures the returned byte when the read strobe is released. Chip select and the bus drive come back half a clock after the read strobe rises.

A ready input from the addressed device is passed through a two-flop synchronizer. It is checked once at the end of the first clock of three phases. If it is low there, that phase runs to a longer fixed length: ALE high for 2 clocks, latch for 3 clocks, data setup for 5 clocks.

The state machine has six states. IDLE goes to HIGH when an extended request is accepted, and to LOW when a normal request is accepted. HIGH goes to LOW after one clock. LOW goes to ALE after one clock. ALE goes to LATCH after 1 or 2 clocks. LATCH goes to STROBE after 1 or 3 clocks. STROBE returns to IDLE after 1 or 5 clocks, and that transition captures the data.

Top module: `mux_rd_master`

## Requirements
- R1: After reset, ALE is low, chip select and read strobe are high (inactive), the bus output enable is high (driving), `req_ready` is high and `rsp_done` is low.
- R2: A request is taken only on a rising edge where `req_ready` is high, and `req_ready` is high only in IDLE. A `req_valid` raised while a cycle runs is ignored: no further ALE pulse follows, and the block returns to IDLE with `req_ready` high.
- R3: On an extended read (`req_ext`=1), `bus_hi_addr` shows `req_addr[15:8]` for one clock before the low address phase, with all strobes inactive. On a normal read this clock is skipped and `bus_hi_addr` keeps its previous value.
- R4: The low address phase lasts exactly one clock. In it, `bus_ad_out` shows `req_addr[7:0]`, output enable is high and ALE is low. ALE rises at the following edge.
- R5: ALE stays high for 1 clock if the synchronized ready is high at the end of its first clock, and for 2 clocks otherwise.
- R6: Chip select goes low exactly one clock after ALE rises, whatever the ready input.
- R7: In the latch phase, ALE is low and chip select is low. The phase lasts 1 clock with ready high and 3 clocks with ready low.
- R8: In the data phase, the read strobe is low, output enable is low (bus is input) and chip select is low. The phase lasts 1 clock with ready high and 5 clocks with ready low.
- R9: The read strobe rises on a rising edge. Chip select and output enable stay low until the next falling edge, then return high.
- R10: `rsp_data` takes `bus_ad_in` as sampled at the rising edge where the read strobe is released. `rsp_done` is high for exactly the one following clock. `rsp_data` holds until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes change on the rising edge, chip select and output enable release on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ext | input | 1 | 1 = 16-bit address read, 0 = 8-bit |
| req_addr | input | 16 | Read address |
| req_ready | output | 1 | High while idle; request accepted when valid and ready |
| rsp_data | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-clock pulse when `rsp_data` is updated |
| bus_hi_addr | output | 8 | Upper address byte port |
| bus_ad_out | output | 8 | Shared bus value when driving |
| bus_ad_oe | output | 1 | 1 = shared bus driven, 0 = high impedance |
| bus_ad_in | input | 8 | Shared bus value seen by the master |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_iordy | input | 1 | Device ready, asynchronous, low requests stretching |

## Verification
Two things can coincide within one clock: the release of the read strobe, which also captures the data, and the pending half-clock release of chip select and bus drive. A third collision is a fresh request arriving while a cycle still runs. The bench samples just after the rising edge that releases the read strobe, and expects chip select still low and the bus still input there. After the falling edge it expects both released, `rsp_done` high and the captured byte equal to the bus value from before that edge. It changes the bus value right after capture and confirms the data holds. It also raises `req_valid` during the latch phase and checks that no second ALE pulse appears.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_ALE,
        ST_LATCH,
        ST_STROBE
    } mrm_state_e;
endpackage

// File: rtl/mrm_sync.sv
module mrm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mrm_half.sv
module mrm_half (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_pos_n,
    input  logic oe_pos,
    output logic cs_n,
    output logic oe
);
    logic cs_neg_n;
    logic oe_neg;

    // Falling-edge copies: assertion follows the rising-edge value at once,
    // release waits for the next falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_neg_n <= 1'b1;
            oe_neg   <= 1'b1;
        end else begin
            cs_neg_n <= cs_pos_n;
            oe_neg   <= oe_pos;
        end
    end

    assign cs_n = cs_pos_n & cs_neg_n;
    assign oe   = oe_pos & oe_neg;
endmodule

// File: rtl/mrm_fsm.sv
module mrm_fsm
    import mrm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ALE_LEN   = 2,
    parameter int LATCH_LEN = 3,
    parameter int SETUP_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rdy,
    input  logic [DATA_W-1:0] bus_in,
    output logic              req_ready,
    output logic              ale,
    output logic              cs_req_n,
    output logic              rd_n,
    output logic              oe_req,
    output logic [DATA_W-1:0] ad_out,
    output logic [ADDR_W-DATA_W-1:0] hi_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done
);
    localparam int MAXLEN = (ALE_LEN > LATCH_LEN) ?
                            ((ALE_LEN > SETUP_LEN) ? ALE_LEN : SETUP_LEN) :
                            ((LATCH_LEN > SETUP_LEN) ? LATCH_LEN : SETUP_LEN);
    localparam int CW = $clog2(MAXLEN + 1);

    mrm_state_e        state, nxt;
    logic [CW-1:0]     cnt, cnt_nxt;
    logic [ADDR_W-1:0] addr_q, addr_use;
    logic              acc;

    function automatic logic phase_done(input logic [CW-1:0] c, input logic r, input int len);
        if (len <= 1)  return 1'b1;
        if (c == '0)   return r;
        return (int'(c) == len - 1);
    endfunction

    assign req_ready = (state == ST_IDLE);
    assign addr_use  = acc ? req_addr : addr_q;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        acc     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (req_valid) begin
                    acc = 1'b1;
                    nxt = req_ext ? ST_HIGH : ST_LOW;
                end
            end
            ST_HIGH:  nxt = ST_LOW;
            ST_LOW: begin
                nxt     = ST_ALE;
                cnt_nxt = '0;
            end
            ST_ALE: begin
                if (phase_done(cnt, rdy, ALE_LEN)) begin
                    nxt = ST_LATCH; cnt_nxt = '0;
                end else cnt_nxt = cnt + 1'b1;
            end
            ST_LATCH: begin
                if (phase_done(cnt, rdy, LATCH_LEN)) begin
                    nxt = ST_STROBE; cnt_nxt = '0;
                end else cnt_nxt = cnt + 1'b1;
            end
            ST_STROBE: begin
                if (phase_done(cnt, rdy, SETUP_LEN)) begin
                    nxt = ST_IDLE; cnt_nxt = '0;
                end else cnt_nxt = cnt + 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (acc) addr_q <= req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale      <= 1'b0;
            cs_req_n <= 1'b1;
            rd_n     <= 1'b1;
            oe_req   <= 1'b1;
            ad_out   <= '0;
            hi_addr  <= '0;
            rsp_data <= '0;
            rsp_done <= 1'b0;
        end else begin
            ale      <= (nxt == ST_ALE);
            cs_req_n <= !((nxt == ST_LATCH) || (nxt == ST_STROBE) ||
                          ((nxt == ST_ALE) && (cnt_nxt != '0)));
            rd_n     <= (nxt != ST_STROBE);
            oe_req   <= (nxt != ST_STROBE);
            ad_out   <= ((nxt == ST_LOW) || (nxt == ST_ALE) || (nxt == ST_LATCH)) ?
                        addr_use[DATA_W-1:0] : '0;
            if (nxt == ST_HIGH) hi_addr <= addr_use[ADDR_W-1:DATA_W];
            rsp_done <= (state == ST_STROBE) && (nxt == ST_IDLE);
            if ((state == ST_STROBE) && (nxt == ST_IDLE)) rsp_data <= bus_in;
        end
    end

    assert_cs_after_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> !cs_req_n);
    assert_ale_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |=> !ale);
    assert_rd_inside_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!cs_req_n && !oe_req && !ale));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    assert_no_ale_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && rd_n));
endmodule

// File: rtl/mux_rd_master.sv
module mux_rd_master #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int SYNC_LEN  = 2,
    parameter int ALE_LEN   = 2,
    parameter int LATCH_LEN = 3,
    parameter int SETUP_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done,
    output logic [ADDR_W-DATA_W-1:0] bus_hi_addr,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    input  logic              bus_iordy
);
    logic rdy_s;
    logic cs_pos_n;
    logic oe_pos;

    mrm_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (bus_iordy),
        .q    (rdy_s)
    );

    mrm_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ALE_LEN  (ALE_LEN),
        .LATCH_LEN(LATCH_LEN),
        .SETUP_LEN(SETUP_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ext  (req_ext),
        .req_addr (req_addr),
        .rdy      (rdy_s),
        .bus_in   (bus_ad_in),
        .req_ready(req_ready),
        .ale      (bus_ale),
        .cs_req_n (cs_pos_n),
        .rd_n     (bus_rd_n),
        .oe_req   (oe_pos),
        .ad_out   (bus_ad_out),
        .hi_addr  (bus_hi_addr),
        .rsp_data (rsp_data),
        .rsp_done (rsp_done)
    );

    mrm_half u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_pos_n(cs_pos_n),
        .oe_pos  (oe_pos),
        .cs_n    (bus_cs_n),
        .oe      (bus_ad_oe)
    );

    // Read strobe release: chip select and drive still off until the falling edge
    assert_cs_holds_at_rd_release_R9: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> (!bus_cs_n && !bus_ad_oe));
    assert_cs_released_after_R9: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |=> (bus_cs_n && bus_ad_oe));
endmodule

// File: tb/mux_rd_master_bench.sv
`timescale 1ns/1ps
module mux_rd_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ext = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic [7:0]  rsp_data;
    logic        rsp_done;
    logic [7:0]  bus_hi_addr;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_ale;
    logic        bus_cs_n;
    logic        bus_rd_n;
    logic        bus_iordy = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mux_rd_master u_mux_rd_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ext    (req_ext),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_data   (rsp_data),
        .rsp_done   (rsp_done),
        .bus_hi_addr(bus_hi_addr),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_ad_in  (bus_ad_in),
        .bus_ale    (bus_ale),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_n   (bus_rd_n),
        .bus_iordy  (bus_iordy)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // {ale, cs_n, rd_n, oe}
    task automatic strobes(input string req, input logic [3:0] exp);
        check(req, {12'h0, bus_ale, bus_cs_n, bus_rd_n, bus_ad_oe}, {12'h0, exp});
    endtask

    task automatic tick;
        @(negedge clk); #1;
    endtask

    task automatic test_reset;
        strobes("R1 reset strobes", 4'b0111);
        check("R1 reset ready/done", {14'h0, req_ready, rsp_done}, 16'h2);
    endtask

    task automatic do_read(input logic ext, input logic [15:0] addr, input logic rdy,
                           input logic [7:0] din, input logic poke);
        logic [7:0] hi_before;
        bus_iordy = rdy;
        bus_ad_in = din;
        repeat (3) tick();
        hi_before = bus_hi_addr;
        check("R2 ready when idle", {15'h0, req_ready}, 16'h1);
        req_valid = 1'b1; req_ext = ext; req_addr = addr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R2 busy after accept", {15'h0, req_ready}, 16'h0);
        if (ext) begin
            tick();
            strobes("R3 high phase strobes", 4'b0111);
            check("R3 high byte", {8'h0, bus_hi_addr}, {8'h0, addr[15:8]});
        end
        tick();
        strobes("R4 low address phase", 4'b0111);
        check("R4 low byte", {8'h0, bus_ad_out}, {8'h0, addr[7:0]});
        tick();
        strobes("R5 ALE first clock", 4'b1111);
        if (!rdy) begin
            tick();
            strobes("R6 CS one clock after ALE", 4'b1011);
        end
        for (int i = 0; i < (rdy ? 1 : 3); i++) begin
            tick();
            strobes("R7 latch phase", 4'b0011);
            check("R7 address held", {8'h0, bus_ad_out}, {8'h0, addr[7:0]});
            if (poke && i == 0) begin
                check("R2 not ready while busy", {15'h0, req_ready}, 16'h0);
                req_valid = 1'b1; req_ext = 1'b1; req_addr = 16'hBEEF;
            end
        end
        for (int i = 0; i < (rdy ? 1 : 5); i++) begin
            tick();
            req_valid = 1'b0;
            strobes("R8 data phase", 4'b0000);
        end
        @(posedge clk); #0.5;
        strobes("R9 half clock after RD release", 4'b0010);
        tick();
        strobes("R9 released", 4'b0111);
        check("R10 done pulse", {15'h0, rsp_done}, 16'h1);
        check("R10 data captured", {8'h0, rsp_data}, {8'h0, din});
        bus_ad_in = ~din;
        tick();
        check("R10 done one clock", {15'h0, rsp_done}, 16'h0);
        check("R10 data held", {8'h0, rsp_data}, {8'h0, din});
        if (!ext)
            check("R3 hi port unchanged on normal read", {8'h0, bus_hi_addr}, {8'h0, hi_before});
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                tick();
                check("R2 ignored request: no ALE, idle", {14'h0, bus_ale, req_ready}, 16'h1);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        test_reset();
        rst_n = 1'b1;
        tick();
        test_reset();
        do_read(1'b0, 16'h1234, 1'b1, 8'hA5, 1'b0);
        do_read(1'b1, 16'hC35A, 1'b1, 8'h3C, 1'b0);
        do_read(1'b0, 16'h0077, 1'b0, 8'h81, 1'b0);
        do_read(1'b1, 16'h9F01, 1'b0, 8'h6E, 1'b0);
        do_read(1'b0, 16'h4242, 1'b1, 8'h19, 1'b1);
        do_read(1'b0, 16'h00F0, 1'b0, 8'hE7, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule